// File: doc/BRIEF.md
# Digital Ppm Trim Seconds Prescaler

This block turns an oscillator-rate clock enable into one pulse per second. It does not use a fixed divide ratio. It sets the number of oscillator enables in each second so that the average rate over an averaging window is corrected by a signed parts-per-million amount.

A 3-bit trim code selects that amount. The code has one direction bit and two magnitude bits. The block counts only the cycles in which the enable is high, so enables may arrive back to back or sparsely on the system clock. At the defaults, the nominal second is 32768 enables and the window is 100 seconds.

The correction is spread evenly: one count per second over the first seconds of each window. No second therefore differs from nominal by more than one count. The trim code is captured once per window, so a change made partway through a window applies from the start of the next window.

Top module: `ppm_tick_prescaler`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and all counting state is cleared. After reset is released, a new second and a new window begin at the first enable, and `trim_i` is captured at that enable.
- R2: `tick_o` is high for exactly one clock cycle per second. It rises in the cycle after the clock edge that samples the terminal enable of a second, and it never rises without that enable.
- R3: When both magnitude bits of the trim code are 0, every second is exactly `NOM_COUNT` enables long, whatever the value of the direction bit `trim_i[2]`.
- R4: The magnitude in ppm is 10 for `trim_i[1]` plus 20 for `trim_i[0]`. Codes `[1:0]` of 00, 10, 01 and 11 therefore give 0, 10, 20 and 30 ppm.
- R5: For each window, the number of corrected counts N equals round(ppm × `NOM_COUNT` × `WIN_SECS` / `PPM_SCALE`), where a half is rounded up. At the defaults, N is 33, 66 or 98.
- R6: With `trim_i[2]` = 0 (positive compensation), seconds 0 to N-1 of the window are `NOM_COUNT`-1 enables long. With `trim_i[2]` = 1 (negative compensation), those seconds are `NOM_COUNT`+1 enables long. All remaining seconds are `NOM_COUNT` enables long.
- R7: `trim_i` is sampled only at the first enable of each window. A change made partway through a window has no effect on that window and takes effect in the next one.
- R8: A window is `WIN_SECS` seconds long. Over one window the enable count is `WIN_SECS`×`NOM_COUNT` − N for positive compensation and `WIN_SECS`×`NOM_COUNT` + N for negative compensation.
- R9: Second lengths depend only on how many enables there are, not on how they are spaced in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator-rate count enable |
| trim_i | input | 3 | Trim code: bit 2 is the direction, bits 1:0 are the magnitude |
| tick_o | output | 1 | One-cycle pulse per second |

## Verification
`tick_o` comes from a single register. It is therefore due in the cycle after the rising edge that samples the terminal enable. The bench drives each enable at a falling edge and reads `tick_o` at the next falling edge, which is the first point where that register's output is settled. In every idle gap cycle between enables, the bench also checks that `tick_o` stays low.

A trim change only becomes visible at the first enable of the following window. For that reason the bench predicts every second from the code that was present when its window began, using the R4 decode and the R5 rounding. It sweeps all eight codes with three different enable spacings.

// File: rtl/ppm_trim_pkg.sv
package ppm_trim_pkg;

  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } trim_t;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_DROP = 2'd1,
    ADJ_ADD  = 2'd2
  } adj_e;

  // rounded counts to move per window for a ppm amount
  function automatic int unsigned corr_counts(input int unsigned ppm,
                                              input int unsigned nom,
                                              input int unsigned win,
                                              input int unsigned scale);
    longint unsigned prod;
    prod = longint'(ppm) * longint'(nom) * longint'(win);
    return int'((prod + longint'(scale / 2)) / longint'(scale));
  endfunction

endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import ppm_trim_pkg::*;
#(
  parameter int unsigned NOM_COUNT = 32768,
  parameter int unsigned WIN_SECS  = 100,
  parameter int unsigned PPM_SCALE = 1000000,
  localparam int unsigned NW = $clog2(WIN_SECS + 1)
) (
  input  trim_t         trim_i,
  output logic [NW-1:0] n_corr_o,
  output logic          neg_o
);

  localparam int unsigned N10 = corr_counts(10, NOM_COUNT, WIN_SECS, PPM_SCALE);
  localparam int unsigned N20 = corr_counts(20, NOM_COUNT, WIN_SECS, PPM_SCALE);
  localparam int unsigned N30 = corr_counts(30, NOM_COUNT, WIN_SECS, PPM_SCALE);

  // bit 1 weighs 10 ppm, bit 0 weighs 20 ppm
  always_comb begin
    unique case (trim_i.mag)
      2'b10:   n_corr_o = NW'(N10);
      2'b01:   n_corr_o = NW'(N20);
      2'b11:   n_corr_o = NW'(N30);
      default: n_corr_o = '0;
    endcase
  end

  assign neg_o = trim_i.neg;

endmodule

// File: rtl/window_seq.sv
module window_seq
  import ppm_trim_pkg::*;
#(
  parameter int unsigned WIN_SECS = 100,
  localparam int unsigned SW = (WIN_SECS > 1) ? $clog2(WIN_SECS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          osc_en_i,
  input  logic          sec_end_i,
  input  trim_t         trim_i,
  output trim_t         eff_trim_o,
  output trim_t         trim_q_o,
  output logic [SW-1:0] sec_idx_o
);

  logic          arm_q;
  trim_t         trim_q;
  logic [SW-1:0] sec_q;

  // first enable of a window uses the live code and latches it
  assign eff_trim_o = arm_q ? trim_i : trim_q;
  assign trim_q_o   = trim_q;
  assign sec_idx_o  = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b1;
      trim_q <= '0;
      sec_q  <= '0;
    end else if (osc_en_i) begin
      if (arm_q) begin
        trim_q <= trim_i;
        arm_q  <= 1'b0;
      end
      if (sec_end_i) begin
        if (sec_q == SW'(WIN_SECS - 1)) begin
          sec_q <= '0;
          arm_q <= 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sec_divider.sv
module sec_divider
  import ppm_trim_pkg::*;
#(
  parameter int unsigned NOM_COUNT = 32768,
  localparam int unsigned CW = $clog2(NOM_COUNT + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  adj_e adj_i,
  output logic sec_end_o,
  output logic tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic          tick_q;

  always_comb begin
    unique case (adj_i)
      ADJ_DROP: last_cnt = CW'(NOM_COUNT - 2);
      ADJ_ADD:  last_cnt = CW'(NOM_COUNT);
      default:  last_cnt = CW'(NOM_COUNT - 1);
    endcase
  end

  assign sec_end_o = (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= osc_en_i && sec_end_o;
      if (osc_en_i) cnt_q <= sec_end_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/ppm_tick_prescaler.sv
module ppm_tick_prescaler
  import ppm_trim_pkg::*;
#(
  parameter int unsigned NOM_COUNT = 32768,
  parameter int unsigned WIN_SECS  = 100,
  parameter int unsigned PPM_SCALE = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic [2:0] trim_i,
  output logic       tick_o
);

  localparam int unsigned NW = $clog2(WIN_SECS + 1);
  localparam int unsigned SW = (WIN_SECS > 1) ? $clog2(WIN_SECS) : 1;

  trim_t         eff_trim;
  trim_t         trim_q;
  logic [SW-1:0] sec_idx;
  logic [NW-1:0] n_corr;
  logic          neg;
  logic          sec_end;
  adj_e          adj;

  window_seq #(.WIN_SECS(WIN_SECS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_en_i  (osc_en_i),
    .sec_end_i (sec_end),
    .trim_i    (trim_t'(trim_i)),
    .eff_trim_o(eff_trim),
    .trim_q_o  (trim_q),
    .sec_idx_o (sec_idx)
  );

  trim_decode #(
    .NOM_COUNT(NOM_COUNT),
    .WIN_SECS (WIN_SECS),
    .PPM_SCALE(PPM_SCALE)
  ) u_dec (
    .trim_i  (eff_trim),
    .n_corr_o(n_corr),
    .neg_o   (neg)
  );

  // one count moved per second over the first n_corr seconds
  always_comb begin
    if (int'(sec_idx) < int'(n_corr)) adj = neg ? ADJ_ADD : ADJ_DROP;
    else                              adj = ADJ_NONE;
  end

  sec_divider #(.NOM_COUNT(NOM_COUNT)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .adj_i    (adj),
    .sec_end_o(sec_end),
    .tick_o   (tick_o)
  );

endmodule

// File: rtl/ppm_tick_prescaler_chk.sv
module ppm_tick_prescaler_chk
  import ppm_trim_pkg::*;
#(
  parameter int unsigned NOM_COUNT = 32768
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  osc_en_i,
  input logic  tick_o,
  input trim_t trim_used_i
);

  int unsigned en_cnt;

  // enables since the previous tick; tick lags its terminal enable by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_cnt <= 0;
    else if (tick_o) en_cnt <= osc_en_i ? 1 : 0;
    else             en_cnt <= en_cnt + (osc_en_i ? 1 : 0);
  end

  // R2
  tick_after_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(osc_en_i));

  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R6
  sec_len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (en_cnt + 1 >= NOM_COUNT) && (en_cnt <= NOM_COUNT + 1));

  // R3
  zero_mag_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && trim_used_i.mag == 2'b00) |-> (en_cnt == NOM_COUNT));

endmodule

bind ppm_tick_prescaler ppm_tick_prescaler_chk #(.NOM_COUNT(NOM_COUNT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_en_i   (osc_en_i),
  .tick_o     (tick_o),
  .trim_used_i(trim_q)
);

// File: tb/ppm_tick_prescaler_tb_top.sv
module ppm_tick_prescaler_tb_top;

  localparam int unsigned NOM = 16;
  localparam int unsigned WIN = 10;
  localparam int unsigned SCL = 1000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b0;
  logic [2:0] trim_i = 3'd0;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ppm_tick_prescaler #(.NOM_COUNT(NOM), .WIN_SECS(WIN), .PPM_SCALE(SCL)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .osc_en_i(osc_en_i),
    .trim_i  (trim_i),
    .tick_o  (tick_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R4 decode and R5 rounding
  function automatic int n_corr(input logic [2:0] code);
    int ppm;
    ppm = (code[1] ? 10 : 0) + (code[0] ? 20 : 0);
    return (ppm * NOM * WIN + SCL / 2) / SCL;
  endfunction

  // R6 per-second length
  function automatic int exp_len(input logic [2:0] code, input int s);
    if (s < n_corr(code)) return code[2] ? NOM + 1 : NOM - 1;
    return NOM;
  endfunction

  task automatic pulse(input int gap, output bit tk);
    osc_en_i = 1'b1;
    @(negedge clk_i);
    tk = tick_o;
    osc_en_i = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      check(!tick_o, "R2 idle tick", int'(tick_o), 0);
    end
  endtask

  task automatic run_second(input int exp, input int gap, input string tag, output int got_len);
    bit tk;
    int n;
    n = 0;
    tk = 1'b0;
    while (!tk && n < int'(NOM) + 4) begin
      pulse(gap, tk);
      n++;
    end
    got_len = n;
    check(n == exp, tag, n, exp);
  endtask

  // code is the one captured at window start; new_code is written after mid_sec seconds
  task automatic run_window(input logic [2:0] code, input int gap, input int mid_sec,
                            input logic [2:0] new_code);
    int len;
    int sum;
    int expsum;
    sum = 0;
    for (int s = 0; s < int'(WIN); s++) begin
      if (s == mid_sec) trim_i = new_code;
      run_second(exp_len(code, s), gap,
                 (mid_sec < int'(WIN)) ? "R7 mid-window change ignored" :
                 (code[1:0] == 2'b00) ? "R3 zero magnitude" : "R4 R5 R6 second length",
                 len);
      sum += len;
    end
    expsum = int'(NOM * WIN) + (code[2] ? n_corr(code) : -n_corr(code));
    check(sum == expsum, "R8 window total", sum, expsum);
  endtask

  initial begin
    int len;
    bit tk;
    repeat (3) @(negedge clk_i);
    check(tick_o == 1'b0, "R1 reset tick low", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(tick_o == 1'b0, "R1 tick low after release", int'(tick_o), 0);

    // R9 sweep all codes with three spacings
    for (int c = 0; c < 8; c++) begin
      trim_i = 3'(c);
      run_window(3'(c), c % 3, int'(WIN), 3'(c));
    end

    // R7 change in mid-window, then next window uses it
    trim_i = 3'b011;
    run_window(3'b011, 1, 4, 3'b111);
    run_window(3'b111, 0, int'(WIN), 3'b111);
    trim_i = 3'b110;
    run_window(3'b110, 2, 3, 3'b001);
    run_window(3'b001, 1, int'(WIN), 3'b001);

    // R1 reset in mid-second restarts counting and window
    for (int k = 0; k < 5; k++) pulse(0, tk);
    trim_i = 3'b101;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(tick_o == 1'b0, "R1 tick low in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_second(exp_len(3'b101, 0), 0, "R1 first second after reset", len);
    check(len == int'(NOM) + 1, "R1 trim captured at first enable", len, int'(NOM) + 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule